// File: doc/BRIEF.md
# Slave-SPI FPGA Configuration Loader

This block brings up an SRAM-based FPGA that takes its image over a slave SPI link. A pulse on `start` runs a fixed sequence on the target. The block first holds the target's active-low reset and chip-select low together. It then releases reset and checks that the target's configuration-done line has gone low. Chip-select stays low through a housekeeping wait, and is then released for a short gap. After the gap the block streams the image bytes as an SPI master in mode 0, most significant bit first. Once the stream ends it checks configuration-done again and, if the line is high, clocks out a zero-filled activation tail. Every delay is counted in system-clock cycles. The SPI half-period is `clk_div` system cycles, latched when the load starts.

Image bytes arrive on a valid/ready byte stream. A byte moves on a cycle in which `s_valid` and `s_ready` are both high. `s_last` marks the final image byte. `s_ready` is high only in the streaming phase and only while the shifter is idle. It drops for the whole 8-bit shift of each accepted byte, so a producer may hold `s_valid` high and wait. The producer must keep `s_data` and `s_last` stable while `s_valid` is high and `s_ready` is low. Status goes out on plain pins: `busy`, a one-cycle `done_pulse`, and a sticky error flag with a 2-bit code.

Top module: `fpga_cfg_loader`

## Requirements
- R1: A start that passes the checks drives `cfg_rst_n` and `cfg_cs_n` low together. `cfg_rst_n` stays low for RST_CYC cycles and `cfg_cs_n` is low whenever `cfg_rst_n` is low.
- R2: After reset release, configuration-done (passed through a two-flop synchroniser) is sampled after SETTLE_CYC cycles. If it is high, the load aborts with code 0 (reset failure) and no SPI clock is produced.
- R3: After reset release, `cfg_cs_n` stays low for SETTLE_CYC + HK_CYC cycles and then goes high for GAP_CYC cycles. `s_ready` never rises before that release.
- R4: SPI mode 0. `cfg_sck` is low whenever `cfg_cs_n` is high. `cfg_mosi` never changes in the cycle `cfg_sck` rises. Each byte goes out MSB first. Each high phase of `cfg_sck` lasts `clk_div` cycles.
- R5: At start, a `clk_div` below DIV_LO = ceil(CLK_HZ / 50 MHz) or above DIV_HI = floor(CLK_HZ / 2 MHz) is rejected with code 3 (bad clock), and `cfg_rst_n` never goes low. With the default 200 MHz these limits are 4 and 100, and both limits are accepted.
- R6: A start with `partial` high is rejected with code 2 (unsupported), and `cfg_rst_n` never goes low. This check takes priority over the clock check.
- R7: A byte moves on `s_valid && s_ready`. `s_ready` is low in the cycle after each transfer. `cfg_cs_n` stays low across the whole stream. Each accepted byte appears on the link in order.
- R8: After the byte marked `s_last` has been shifted out, configuration-done is sampled after SETTLE_CYC cycles. If it is low, the load ends with code 1 (not done) and no tail bytes are sent.
- R9: If configuration-done is high, 7 zero bytes (the 49-clock minimum rounded up to whole bytes) follow the image. The load then ends with exactly one `done_pulse` cycle.
- R10: `busy` is high from the cycle after an accepted start until the load ends. `err_flag` and `err_code` hold until the next start, which clears them. `done_pulse` never coincides with `err_flag`.
- R11: A `start` pulse while `busy` is high is ignored, even with `partial` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset of the block |
| start | input | 1 | Begin a load (pulse) |
| partial | input | 1 | Request is a partial reconfiguration (rejected) |
| clk_div | input | DIV_W | SPI half-period in system cycles |
| s_valid | input | 1 | Image byte valid |
| s_data | input | 8 | Image byte |
| s_last | input | 1 | Marks the final image byte |
| s_ready | output | 1 | Block accepts a byte |
| cfg_rst_n | output | 1 | Target reset, active low |
| cfg_cs_n | output | 1 | Target chip-select, active low |
| cfg_sck | output | 1 | SPI clock, idle low |
| cfg_mosi | output | 1 | SPI data to target |
| cfg_done_in | input | 1 | Target configuration-done, asynchronous |
| busy | output | 1 | A load is in progress |
| done_pulse | output | 1 | One-cycle pulse on a successful load |
| err_flag | output | 1 | Sticky: the last load failed |
| err_code | output | 2 | 0 reset failure, 1 not done, 2 unsupported, 3 bad clock |

## Verification
The bench builds the block with the default 200 MHz clock rate, which puts the divider limits at 4 and 100. It shortens the reset hold to 50 cycles and the housekeeping wait to 300 cycles. With these values, loads at both divider limits, at both rejected neighbours (3 and 101) and at every abort path fit in a short run. A small model of the target counts SPI clocks to decide when to raise configuration-done, or forces it high to test the reset-failure path.

// File: rtl/cfg_load_pkg.sv
`timescale 1ns/1ps
package cfg_load_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RESET,
    ST_SETTLE,
    ST_HOUSE,
    ST_GAP,
    ST_STREAM,
    ST_DRAIN,
    ST_VERIFY,
    ST_TAIL
  } cfg_state_e;

  typedef enum logic [1:0] {
    ERR_RESET_FAIL  = 2'd0,
    ERR_NOT_DONE    = 2'd1,
    ERR_UNSUPPORTED = 2'd2,
    ERR_BAD_CLOCK   = 2'd3
  } cfg_err_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/cfg_sync2.sv
`timescale 1ns/1ps
module cfg_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic meta;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta   <= 1'b0;
      q_sync <= 1'b0;
    end else begin
      meta   <= d_async;
      q_sync <= meta;
    end
  end
endmodule

// File: rtl/cfg_spi_byte.sv
`timescale 1ns/1ps
// Mode-0 byte serialiser: sck idles low, data moves on the falling edge.
module cfg_spi_byte #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [7:0]       din,
  input  logic [DIV_W-1:0] div,
  output logic             busy,
  output logic             sck,
  output logic             mosi
);
  logic [DIV_W-1:0] half_cnt;
  logic [2:0]       bit_idx;
  logic [7:0]       shreg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      sck      <= 1'b0;
      half_cnt <= '0;
      bit_idx  <= '0;
      shreg    <= '0;
    end else if (load && !busy) begin
      busy     <= 1'b1;
      sck      <= 1'b0;
      half_cnt <= '0;
      bit_idx  <= '0;
      shreg    <= din;
    end else if (busy) begin
      if (half_cnt == div - DIV_W'(1)) begin
        half_cnt <= '0;
        sck      <= ~sck;
        if (sck) begin
          if (bit_idx == 3'd7) begin
            busy <= 1'b0;
          end else begin
            bit_idx <= bit_idx + 3'd1;
            shreg   <= {shreg[6:0], 1'b0};
          end
        end
      end else begin
        half_cnt <= half_cnt + DIV_W'(1);
      end
    end
  end

  assign mosi = shreg[7];
endmodule

// File: rtl/fpga_cfg_loader.sv
`timescale 1ns/1ps
module fpga_cfg_loader
  import cfg_load_pkg::*;
#(
  parameter int CLK_HZ     = 200_000_000,
  parameter int SCK_MIN_HZ = 1_000_000,
  parameter int SCK_MAX_HZ = 25_000_000,
  parameter int RST_CYC    = CLK_HZ / 1_000_000,
  parameter int HK_CYC     = (CLK_HZ / 1_000_000) * 1200,
  parameter int SETTLE_CYC = 4,
  parameter int GAP_CYC    = 4,
  parameter int TAIL_BITS  = 49,
  parameter int DIV_W      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             partial,
  input  logic [DIV_W-1:0] clk_div,
  input  logic             s_valid,
  input  logic [7:0]       s_data,
  input  logic             s_last,
  output logic             s_ready,
  output logic             cfg_rst_n,
  output logic             cfg_cs_n,
  output logic             cfg_sck,
  output logic             cfg_mosi,
  input  logic             cfg_done_in,
  output logic             busy,
  output logic             done_pulse,
  output logic             err_flag,
  output logic [1:0]       err_code
);
  localparam int DIV_LO     = (CLK_HZ + 2 * SCK_MAX_HZ - 1) / (2 * SCK_MAX_HZ);
  localparam int DIV_HI     = CLK_HZ / (2 * SCK_MIN_HZ);
  localparam int TAIL_BYTES = (TAIL_BITS + 7) / 8;
  localparam int CNT_MAX    = max2(max2(RST_CYC, HK_CYC), max2(SETTLE_CYC, GAP_CYC));
  localparam int CNT_W      = $clog2(CNT_MAX + 1);
  localparam int TL_W       = $clog2(TAIL_BYTES + 1);
  localparam logic [DIV_W-1:0] DIV_LO_V = DIV_W'(DIV_LO);
  localparam logic [DIV_W-1:0] DIV_HI_V = DIV_W'(DIV_HI);

  cfg_state_e       state;
  cfg_err_e         err_q;
  logic [CNT_W-1:0] cnt;
  logic [TL_W-1:0]  tail_cnt;
  logic [DIV_W-1:0] div_q;
  logic             done_s;
  logic             sh_busy;
  logic             sh_load;
  logic [7:0]       sh_din;
  logic             take;
  logic             div_bad;

  cfg_sync2 u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (cfg_done_in),
    .q_sync  (done_s)
  );

  cfg_spi_byte #(.DIV_W(DIV_W)) u_shift (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (sh_load),
    .din   (sh_din),
    .div   (div_q),
    .busy  (sh_busy),
    .sck   (cfg_sck),
    .mosi  (cfg_mosi)
  );

  assign div_bad = (clk_div < DIV_LO_V) || (clk_div > DIV_HI_V);
  assign s_ready = (state == ST_STREAM) && !sh_busy;
  assign take    = s_valid && s_ready;
  assign sh_load = take ||
                   ((state == ST_TAIL) && !sh_busy && (tail_cnt != TL_W'(TAIL_BYTES)));
  assign sh_din  = (state == ST_TAIL) ? 8'h00 : s_data;

  always_comb begin
    cfg_rst_n = (state != ST_RESET);
    case (state)
      ST_RESET, ST_SETTLE, ST_HOUSE, ST_STREAM,
      ST_DRAIN, ST_VERIFY, ST_TAIL: cfg_cs_n = 1'b0;
      default:                      cfg_cs_n = 1'b1;
    endcase
  end

  assign busy     = (state != ST_IDLE);
  assign err_code = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      err_q      <= ERR_RESET_FAIL;
      err_flag   <= 1'b0;
      done_pulse <= 1'b0;
      cnt        <= '0;
      tail_cnt   <= '0;
      div_q      <= DIV_LO_V;
    end else begin
      done_pulse <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            err_flag <= 1'b0;
            err_q    <= ERR_RESET_FAIL;
            if (partial) begin
              err_flag <= 1'b1;
              err_q    <= ERR_UNSUPPORTED;
            end else if (div_bad) begin
              err_flag <= 1'b1;
              err_q    <= ERR_BAD_CLOCK;
            end else begin
              state <= ST_RESET;
              cnt   <= '0;
              div_q <= clk_div;
            end
          end
        end
        ST_RESET: begin
          if (cnt == CNT_W'(RST_CYC - 1)) begin
            state <= ST_SETTLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_SETTLE: begin
          if (cnt == CNT_W'(SETTLE_CYC - 1)) begin
            cnt <= '0;
            if (done_s) begin
              state    <= ST_IDLE;
              err_flag <= 1'b1;
              err_q    <= ERR_RESET_FAIL;
            end else begin
              state <= ST_HOUSE;
            end
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_HOUSE: begin
          if (cnt == CNT_W'(HK_CYC - 1)) begin
            state <= ST_GAP;
            cnt   <= '0;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_GAP: begin
          if (cnt == CNT_W'(GAP_CYC - 1)) begin
            state <= ST_STREAM;
            cnt   <= '0;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_STREAM: begin
          if (take && s_last) state <= ST_DRAIN;
        end
        ST_DRAIN: begin
          if (!sh_busy) begin
            state <= ST_VERIFY;
            cnt   <= '0;
          end
        end
        ST_VERIFY: begin
          if (cnt == CNT_W'(SETTLE_CYC - 1)) begin
            cnt <= '0;
            if (done_s) begin
              state    <= ST_TAIL;
              tail_cnt <= '0;
            end else begin
              state    <= ST_IDLE;
              err_flag <= 1'b1;
              err_q    <= ERR_NOT_DONE;
            end
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_TAIL: begin
          if (!sh_busy) begin
            if (tail_cnt == TL_W'(TAIL_BYTES)) begin
              state      <= ST_IDLE;
              done_pulse <= 1'b1;
            end else begin
              tail_cnt <= tail_cnt + TL_W'(1);
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fpga_cfg_loader_chk.sv
`timescale 1ns/1ps
module fpga_cfg_loader_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       partial,
  input logic       s_valid,
  input logic       s_ready,
  input logic       cfg_rst_n,
  input logic       cfg_cs_n,
  input logic       cfg_sck,
  input logic       cfg_mosi,
  input logic       busy,
  input logic       done_pulse,
  input logic       err_flag,
  input logic [1:0] err_code
);
  AST_RST_WITH_CS: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rst_n |-> !cfg_cs_n); // R1
  AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_cs_n |-> !cfg_sck); // R4
  AST_MOSI_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_sck) |-> $stable(cfg_mosi)); // R4
  AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> !s_ready); // R7
  AST_READY_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> (!cfg_cs_n && cfg_rst_n)); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> !done_pulse); // R9
  AST_DONE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> (!err_flag && !busy)); // R10
  AST_PARTIAL_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && partial) |=> (cfg_rst_n && err_flag && err_code == 2'd2)); // R6
  AST_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy && !err_flag) |=> !err_flag || !busy); // R11
endmodule

bind fpga_cfg_loader fpga_cfg_loader_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .partial    (partial),
  .s_valid    (s_valid),
  .s_ready    (s_ready),
  .cfg_rst_n  (cfg_rst_n),
  .cfg_cs_n   (cfg_cs_n),
  .cfg_sck    (cfg_sck),
  .cfg_mosi   (cfg_mosi),
  .busy       (busy),
  .done_pulse (done_pulse),
  .err_flag   (err_flag),
  .err_code   (err_code)
);

// File: tb/fpga_cfg_loader_test.sv
`timescale 1ns/1ps
module fpga_cfg_loader_test;
  localparam int RST_C = 50;
  localparam int HK_C  = 300;
  localparam int SET_C = 4;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, partial = 1'b0;
  logic [7:0] clk_div = 8'd4;
  logic s_valid = 1'b0, s_last = 1'b0;
  logic [7:0] s_data = 8'h00;
  logic s_ready, cfg_rst_n, cfg_cs_n, cfg_sck, cfg_mosi, cfg_done_in;
  logic busy, done_pulse, err_flag;
  logic [1:0] err_code;

  always #2.5 clk = ~clk;

  fpga_cfg_loader #(.RST_CYC(RST_C), .HK_CYC(HK_C), .SETTLE_CYC(SET_C)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .partial(partial), .clk_div(clk_div),
    .s_valid(s_valid), .s_data(s_data), .s_last(s_last), .s_ready(s_ready),
    .cfg_rst_n(cfg_rst_n), .cfg_cs_n(cfg_cs_n), .cfg_sck(cfg_sck), .cfg_mosi(cfg_mosi),
    .cfg_done_in(cfg_done_in), .busy(busy), .done_pulse(done_pulse),
    .err_flag(err_flag), .err_code(err_code)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // target model: done rises once enough image clocks arrived
  int tgt_bits = 0, tgt_need = 0;
  bit tgt_force = 0, tgt_ok = 0;
  always @(posedge cfg_sck or negedge cfg_rst_n)
    if (!cfg_rst_n) tgt_bits = 0;
    else if (!cfg_cs_n) tgt_bits++;
  assign cfg_done_in = tgt_force || (tgt_ok && cfg_rst_n && tgt_need > 0 && tgt_bits >= tgt_need);

  // scoreboard
  logic [7:0] exp_q[$];
  logic [7:0] rx_sh = 8'h00;
  int rx_bits = 0, rx_count = 0, sck_edges = 0;
  always @(posedge cfg_sck or posedge cfg_cs_n) begin
    if (cfg_cs_n) rx_bits = 0;
    else begin
      sck_edges++;
      rx_sh = {rx_sh[6:0], cfg_mosi};
      rx_bits++;
      if (rx_bits == 8) begin
        rx_bits = 0;
        rx_count++;
        if (exp_q.size() == 0) chk(0, "R7 unexpected byte", int'(rx_sh), -1);
        else begin
          automatic logic [7:0] e = exp_q.pop_front();
          chk(rx_sh == e, "R4/R7/R9 byte on link (MSB first)", int'(rx_sh), int'(e));
        end
      end
    end
  end

  // pin monitor
  int rst_run = 0, rst_len = 0, rst_falls = 0, rst_cs_bad = 0;
  int hk_cnt = 0, hk_len = 0, hi_run = 0, hi_len = 0, done_cnt = 0;
  int early_ready = 0, idle_sck = 0;
  bit hk_meas = 0, gap_seen = 0, prev_rst = 1;
  always @(negedge clk) begin
    if (!cfg_rst_n) begin
      rst_run++;
      if (cfg_cs_n) rst_cs_bad++;
      if (prev_rst) rst_falls++;
    end else if (!prev_rst) begin
      rst_len = rst_run; rst_run = 0; hk_meas = 1; hk_cnt = 0;
    end
    if (hk_meas) begin
      if (!cfg_cs_n) hk_cnt++;
      else begin hk_meas = 0; hk_len = hk_cnt; gap_seen = 1; end
    end
    prev_rst = cfg_rst_n;
    if (cfg_sck) hi_run++;
    else if (hi_run > 0) begin hi_len = hi_run; hi_run = 0; end
    if (done_pulse) done_cnt++;
    if (s_ready && !gap_seen) early_ready++;
    if (cfg_cs_n && cfg_sck) idle_sck++;
  end

  task automatic clear_stats();
    exp_q.delete();
    rx_count = 0; sck_edges = 0; rst_len = 0; rst_falls = 0; rst_cs_bad = 0;
    hk_len = 0; hi_len = 0; done_cnt = 0; early_ready = 0; gap_seen = 0; idle_sck = 0;
  endtask

  function automatic logic [7:0] img_byte(input int i);
    return 8'(8'hA5 + i * 8'h4B);
  endfunction

  // driver: pushes expected bytes, runs a full load
  task automatic run(input logic [7:0] div, input int n, input bit ok, input bit poke);
    clear_stats();
    tgt_need = 8 * n; tgt_ok = ok;
    for (int i = 0; i < n; i++) exp_q.push_back(img_byte(i));
    if (ok) for (int i = 0; i < 7; i++) exp_q.push_back(8'h00);
    @(negedge clk); start = 1; partial = 0; clk_div = div;
    @(negedge clk); start = 0;
    chk(busy == 1'b1, "R10 busy after start", int'(busy), 1);
    for (int i = 0; i < n; i++) begin
      s_valid = 1; s_data = img_byte(i); s_last = (i == n - 1);
      while (!s_ready) @(negedge clk);
      @(negedge clk);
      s_valid = 0; s_last = 0;
      if (poke && i == 0) begin
        start = 1; partial = 1; @(negedge clk); start = 0; partial = 0;
      end
      if (i % 2 == 1) @(negedge clk);
    end
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic bad_start(input logic [7:0] div, input bit part);
    clear_stats();
    @(negedge clk); start = 1; partial = part; clk_div = div;
    @(negedge clk); start = 0; partial = 0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(cfg_rst_n == 1'b1 && cfg_cs_n == 1'b1, "R1 pins idle in reset", int'({cfg_rst_n, cfg_cs_n}), 3);
    chk(cfg_sck == 1'b0, "R4 sck idle low in reset", int'(cfg_sck), 0);
    chk(busy == 1'b0 && err_flag == 1'b0 && s_ready == 1'b0, "R10 status in reset",
        int'({busy, err_flag, s_ready}), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // low divider limit, five bytes
    run(8'd4, 5, 1, 0);
    chk(rst_len >= RST_C && rst_len <= RST_C + 2, "R1 reset hold", rst_len, RST_C);
    chk(rst_cs_bad == 0, "R1 cs low with reset", rst_cs_bad, 0);
    chk(hk_len >= SET_C + HK_C && hk_len <= SET_C + HK_C + 2, "R3 housekeeping window", hk_len, SET_C + HK_C);
    chk(early_ready == 0, "R3 ready before gap", early_ready, 0);
    chk(hi_len == 4, "R4 sck high phase", hi_len, 4);
    chk(idle_sck == 0, "R4 sck while cs high", idle_sck, 0);
    chk(rx_count == 12, "R9 image plus tail bytes", rx_count, 12);
    chk(exp_q.size() == 0, "R7 all bytes seen", exp_q.size(), 0);
    chk(done_cnt == 1, "R9 one done pulse", done_cnt, 1);
    chk(err_flag == 1'b0 && busy == 1'b0, "R10 clean finish", int'({err_flag, busy}), 0);

    // high divider limit
    run(8'd100, 2, 1, 0);
    chk(hi_len == 100, "R5 top divider accepted", hi_len, 100);
    chk(rx_count == 9 && exp_q.size() == 0, "R9 short image tail", rx_count, 9);
    chk(done_cnt == 1, "R9 done pulse slow", done_cnt, 1);

    // partial request
    bad_start(8'd4, 1);
    chk(err_flag && err_code == 2'd2, "R6 unsupported code", int'(err_code), 2);
    chk(rst_falls == 0 && sck_edges == 0, "R6 no pin activity", rst_falls + sck_edges, 0);
    bad_start(8'd3, 1);
    chk(err_code == 2'd2, "R6 priority over clock", int'(err_code), 2);

    // divider out of range
    bad_start(8'd3, 0);
    chk(err_flag && err_code == 2'd3, "R5 divider 3 rejected", int'(err_code), 3);
    bad_start(8'd101, 0);
    chk(err_flag && err_code == 2'd3, "R5 divider 101 rejected", int'(err_code), 3);
    chk(rst_falls == 0, "R5 reset untouched", rst_falls, 0);

    // done stuck high during reset
    clear_stats();
    tgt_force = 1;
    @(negedge clk); start = 1; clk_div = 8'd4;
    @(negedge clk); start = 0;
    while (busy) @(negedge clk);
    tgt_force = 0;
    @(negedge clk);
    chk(err_flag && err_code == 2'd0, "R2 reset failure code", int'(err_code), 0);
    chk(sck_edges == 0 && rx_count == 0, "R2 no stream", sck_edges, 0);
    chk(cfg_cs_n == 1'b1, "R2 cs released", int'(cfg_cs_n), 1);

    // target never finishes
    run(8'd5, 3, 0, 0);
    chk(err_flag && err_code == 2'd1, "R8 not-done code", int'(err_code), 1);
    chk(rx_count == 3, "R8 no tail bytes", rx_count, 3);
    chk(done_cnt == 0, "R8 no done pulse", done_cnt, 0);

    // next start clears the error; start during stream ignored
    run(8'd6, 4, 1, 1);
    chk(err_flag == 1'b0, "R10 error cleared / R11 poke ignored", int'(err_flag), 0);
    chk(done_cnt == 1 && rx_count == 11, "R11 load completed", rx_count, 11);

    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule